// File: doc/BRIEF.md
# Page Table Refill Descriptor Engine

This block loads physical page addresses into a small two-dimensional slot table used by an address-translation path. Software hands each engine the address of a descriptor in memory. The engine follows the chain of descriptors that starts there. Each descriptor names a rectangle of slots and points at an array of 32-bit entries. The engine copies the entries into the rectangle, then moves to the next descriptor.

All engines share one memory read port, which carries one outstanding read at a time. Each engine exposes a descriptor register and a status register. A shared interrupt register gives each engine an 8-bit field of sticky event bits. Software clears these bits by writing ones to them. A per-bit enable mask gates the pending bits onto one interrupt line. A lookup port reads the slot table back for the translation datapath.

Top module: `pt_refill_unit`

## Requirements
- R1: After reset every engine reports ready (status bit 0 = 1) with error (status bit 1) clear. The interrupt status register reads zero, `irq_o` is low and every table slot reads zero.
- R2: A descriptor is four 32-bit words at a 16-byte-aligned address. Word +0 holds the rectangle, with x0 in [7:0], y0 in [15:8], x1 in [23:16] and y1 in [31:24]. Word +4 holds control, with the start flag in bit 0. Word +8 holds the data pointer and word +12 holds the next-descriptor pointer. A next pointer of zero ends the chain.
- R3: A descriptor with start set writes (x1-x0+1)*(y1-y0+1) slots in row-major order from (x0,y0). Entry k comes from data pointer + 4k.
- R4: A descriptor with start clear writes no slot, and the walk continues with its next descriptor.
- R5: A nonzero write to engine n's descriptor register (word address 4+n) starts a walk when the engine is ready. Ready stays low until the chain ends, and the register reads back the current descriptor address.
- R6: Writing zero to a descriptor register cancels the walk. The engine writes no further slots, raises no chain-done bit and becomes ready once any read in flight has returned.
- R7: Any of these faults sets the engine's error status bit and its interrupt error bit (bit 2 of its field), and abandons the chain without writing that descriptor's slots: a descriptor address with nonzero bits [3:0], x1<x0, y1<y0, or a coordinate outside the table. The next start clears the error bit.
- R8: Engine n owns interrupt status bits [8n+7:8n] (word address 0). Bit 1 is set when its chain ends, bit 7 when any of its descriptors finishes, and bit 2 on a fault. Bit 0 always reads zero. Writing ones clears bits, and an event in the same cycle as a clear leaves its bit set.
- R9: `irq_o` is high exactly when some interrupt status bit and the same bit of the enable register (word address 1) are both set.
- R10: Engines started together both complete correctly through the shared read port, which has at most one read in flight. The lowest-numbered requester wins.
- R11: A nonzero descriptor write to an engine that is not ready is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 4 | Register write word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 4 | Register read word address |
| reg_rdata_o | output | 32 | Register read data, combinational |
| mem_req_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | AW | Memory read byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| lut_x_i | input | XW | Table lookup column |
| lut_y_i | input | YW | Table lookup row |
| lut_data_o | output | 32 | Table lookup entry |
| irq_o | output | 1 | Interrupt request |

## Verification
Software's write-one-to-clear of the chain-done bit can land in the same cycle in which the engine sets that bit. The bench creates this overlap by writing the clear for engine 0's done bit on every cycle while the chain runs. It drops the write in the first cycle that ready is seen high. The done bit must still read back as set. A cancel that arrives while a read is in flight is also covered: the bench checks that the late response writes no slot and that ready waits for it.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [1:0] {W_IDLE, W_DESC, W_DATA} walk_st_e;

  typedef struct packed {
    logic [7:0] y1;
    logic [7:0] x1;
    logic [7:0] y0;
    logic [7:0] x0;
  } rect_t;

  localparam int unsigned FIELD_W = 8;
  localparam int unsigned IB_LAST = 1;
  localparam int unsigned IB_ERR  = 2;
  localparam int unsigned IB_FILL = 7;
endpackage

// File: rtl/ptr_slot_table.sv
module ptr_slot_table #(
  parameter int unsigned TW = 8,
  parameter int unsigned TH = 4,
  parameter int unsigned XW = 3,
  parameter int unsigned YW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [XW-1:0] wx_i,
  input  logic [YW-1:0] wy_i,
  input  logic [31:0]   wd_i,
  input  logic [XW-1:0] rx_i,
  input  logic [YW-1:0] ry_i,
  output logic [31:0]   rd_o
);
  localparam int unsigned NS   = TW * TH;
  localparam int unsigned IDXW = $clog2(NS);

  logic [31:0]   slot_q [NS];
  logic [IDXW-1:0] w_idx, r_idx;

  assign w_idx = IDXW'(wy_i) * IDXW'(TW) + IDXW'(wx_i);
  assign r_idx = IDXW'(ry_i) * IDXW'(TW) + IDXW'(rx_i);
  assign rd_o  = slot_q[r_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NS; i++) slot_q[i] <= '0;
    end else if (we_i) begin
      slot_q[w_idx] <= wd_i;
    end
  end
endmodule

// File: rtl/ptr_port_arb.sv
module ptr_port_arb #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         rvalid_i,
  output logic [N-1:0] gnt_o,
  output logic [N-1:0] own_o
);
  logic [N-1:0] owner_q;

  always_comb begin
    gnt_o = '0;
    if (owner_q == '0) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (req_i[i]) begin
          gnt_o    = '0;
          gnt_o[i] = 1'b1;
        end
      end
    end
  end

  assign own_o = owner_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          owner_q <= '0;
    else if (rvalid_i)    owner_q <= '0;
    else if (|gnt_o)      owner_q <= gnt_o;
  end

  assert_single_owner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner_q));

  assert_hold_owner_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q != '0 && !rvalid_i) |=> $stable(owner_q));
endmodule

// File: rtl/ptr_walker.sv
module ptr_walker
  import ptr_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 8,
  parameter int unsigned TH = 4,
  parameter int unsigned XW = 3,
  parameter int unsigned YW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cancel_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          gnt_i,
  input  logic          rvalid_i,
  input  logic [31:0]   rdata_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          ready_o,
  output logic          err_o,
  output logic [AW-1:0] cur_ptr_o,
  output logic          done_o,
  output logic          fill_o,
  output logic          fault_o,
  output logic          tw_en_o,
  output logic [XW-1:0] tw_x_o,
  output logic [YW-1:0] tw_y_o,
  output logic [31:0]   tw_d_o
);
  walk_st_e      st_q;
  logic          wait_q, ctrl_q, err_q;
  logic [1:0]    widx_q;
  logic [AW-1:0] ptr_q, dptr_q, next_q;
  rect_t         rect_q;
  logic [7:0]    cx_q, cy_q;

  logic desc_misal, take, rect_bad, last_cell, fin_desc, word3;
  logic [AW-1:0] nxt;

  assign desc_misal = (st_q == W_DESC) && (widx_q == 2'd0) && !wait_q && (ptr_q[3:0] != 4'd0);
  assign take       = rvalid_i && wait_q;
  assign word3      = take && (st_q == W_DESC) && (widx_q == 2'd3);
  assign rect_bad   = (rect_q.x1 < rect_q.x0) || (rect_q.y1 < rect_q.y0) ||
                      ({1'b0, rect_q.x1} >= 9'(TW)) || ({1'b0, rect_q.y1} >= 9'(TH));
  assign last_cell  = (cx_q == rect_q.x1) && (cy_q == rect_q.y1);
  assign nxt        = word3 ? AW'(rdata_i) : next_q;
  assign fin_desc   = (word3 && !rect_bad && !ctrl_q) ||
                      (take && (st_q == W_DATA) && last_cell);

  assign req_o     = !wait_q && (((st_q == W_DESC) && !desc_misal) || (st_q == W_DATA));
  assign addr_o    = (st_q == W_DATA) ? dptr_q : ptr_q + AW'({widx_q, 2'b00});
  assign ready_o   = (st_q == W_IDLE) && !wait_q;
  assign err_o     = err_q;
  assign cur_ptr_o = ptr_q;
  assign fill_o    = fin_desc && !cancel_i;
  assign done_o    = fin_desc && !cancel_i && (nxt == '0);
  assign fault_o   = !cancel_i && (desc_misal || (word3 && rect_bad));
  assign tw_en_o   = take && (st_q == W_DATA) && !cancel_i;
  assign tw_x_o    = cx_q[XW-1:0];
  assign tw_y_o    = cy_q[YW-1:0];
  assign tw_d_o    = rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= W_IDLE;
      wait_q <= 1'b0;
      ctrl_q <= 1'b0;
      err_q  <= 1'b0;
      widx_q <= '0;
      ptr_q  <= '0;
      dptr_q <= '0;
      next_q <= '0;
      rect_q <= '0;
      cx_q   <= '0;
      cy_q   <= '0;
    end else begin
      if (req_o && gnt_i) wait_q <= 1'b1;
      else if (rvalid_i)  wait_q <= 1'b0;

      if (cancel_i) begin
        st_q  <= W_IDLE;
        err_q <= 1'b0;
      end else begin
        case (st_q)
          W_IDLE: if (start_i) begin
            st_q   <= W_DESC;
            widx_q <= '0;
            ptr_q  <= ptr_i;
            err_q  <= 1'b0;
          end
          W_DESC: begin
            if (desc_misal) begin
              st_q  <= W_IDLE;
              err_q <= 1'b1;
            end else if (take) begin
              widx_q <= widx_q + 2'd1;
              case (widx_q)
                2'd0: rect_q <= rdata_i;
                2'd1: ctrl_q <= rdata_i[0];
                2'd2: dptr_q <= AW'(rdata_i);
                default: begin
                  next_q <= AW'(rdata_i);
                  if (rect_bad) begin
                    st_q  <= W_IDLE;
                    err_q <= 1'b1;
                  end else if (!ctrl_q) begin
                    // skipped descriptor: follow link, widx wraps to 0
                    if (rdata_i == '0) st_q <= W_IDLE;
                    else ptr_q <= AW'(rdata_i);
                  end else begin
                    st_q <= W_DATA;
                    cx_q <= rect_q.x0;
                    cy_q <= rect_q.y0;
                  end
                end
              endcase
            end
          end
          W_DATA: if (take) begin
            dptr_q <= dptr_q + AW'(4);
            if (last_cell) begin
              if (next_q == '0) st_q <= W_IDLE;
              else begin
                st_q   <= W_DESC;
                ptr_q  <= next_q;
                widx_q <= '0;
              end
            end else if (cx_q == rect_q.x1) begin
              cx_q <= rect_q.x0;
              cy_q <= cy_q + 8'd1;
            end else begin
              cx_q <= cx_q + 8'd1;
            end
          end
          default: st_q <= W_IDLE;
        endcase
      end
    end
  end

  assert_in_rect_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tw_en_o |-> (cx_q >= rect_q.x0 && cx_q <= rect_q.x1 && cy_q >= rect_q.y0 && cy_q <= rect_q.y1));

  assert_done_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);

  assert_cancel_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> (st_q == W_IDLE));

  assert_fault_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (err_o && ready_o));
endmodule

// File: rtl/pt_refill_unit.sv
module pt_refill_unit
  import ptr_pkg::*;
#(
  parameter int unsigned N_ENG = 2,
  parameter int unsigned AW    = 32,
  parameter int unsigned TBL_W = 8,
  parameter int unsigned TBL_H = 4,
  localparam int unsigned XW   = $clog2(TBL_W),
  localparam int unsigned YW   = $clog2(TBL_H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_waddr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic [3:0]    reg_raddr_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic [XW-1:0] lut_x_i,
  input  logic [YW-1:0] lut_y_i,
  output logic [31:0]   lut_data_o,
  output logic          irq_o
);
  localparam int unsigned IW = FIELD_W * N_ENG;

  logic [N_ENG-1:0] req, gnt, own, ready, err, done, fill, fault, tw_en, start, cancel;
  logic [AW-1:0]    w_addr  [N_ENG];
  logic [AW-1:0]    w_ptr   [N_ENG];
  logic [XW-1:0]    w_x     [N_ENG];
  logic [YW-1:0]    w_y     [N_ENG];
  logic [31:0]      w_d     [N_ENG];
  logic [IW-1:0]    stat_q, en_q, set_v, clr_v;

  ptr_port_arb #(.N(N_ENG)) u_arb (
    .clk_i, .rst_ni, .req_i(req), .rvalid_i(mem_rvalid_i), .gnt_o(gnt), .own_o(own)
  );

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    localparam logic [3:0] DADDR = 4'(4 + g);
    assign start[g]  = reg_we_i && (reg_waddr_i == DADDR) && (reg_wdata_i != '0) && ready[g];
    assign cancel[g] = reg_we_i && (reg_waddr_i == DADDR) && (reg_wdata_i == '0);

    ptr_walker #(.AW(AW), .TW(TBL_W), .TH(TBL_H), .XW(XW), .YW(YW)) u_walk (
      .clk_i, .rst_ni,
      .start_i(start[g]), .cancel_i(cancel[g]), .ptr_i(AW'(reg_wdata_i)),
      .gnt_i(gnt[g]), .rvalid_i(mem_rvalid_i && own[g]), .rdata_i(mem_rdata_i),
      .req_o(req[g]), .addr_o(w_addr[g]), .ready_o(ready[g]), .err_o(err[g]),
      .cur_ptr_o(w_ptr[g]), .done_o(done[g]), .fill_o(fill[g]), .fault_o(fault[g]),
      .tw_en_o(tw_en[g]), .tw_x_o(w_x[g]), .tw_y_o(w_y[g]), .tw_d_o(w_d[g])
    );

    assert_done_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done[g] |=> stat_q[FIELD_W*g + IB_LAST]);
  end

  // shared port and table write: at most one engine active at a time
  logic          t_we;
  logic [XW-1:0] t_x;
  logic [YW-1:0] t_y;
  logic [31:0]   t_d;

  always_comb begin
    mem_addr_o = '0;
    t_x = '0;
    t_y = '0;
    t_d = '0;
    for (int n = 0; n < N_ENG; n++) begin
      if (gnt[n])   mem_addr_o = mem_addr_o | w_addr[n];
      if (tw_en[n]) begin
        t_x = t_x | w_x[n];
        t_y = t_y | w_y[n];
        t_d = t_d | w_d[n];
      end
    end
  end
  assign mem_req_o = |gnt;
  assign t_we      = |tw_en;

  ptr_slot_table #(.TW(TBL_W), .TH(TBL_H), .XW(XW), .YW(YW)) u_tbl (
    .clk_i, .rst_ni, .we_i(t_we), .wx_i(t_x), .wy_i(t_y), .wd_i(t_d),
    .rx_i(lut_x_i), .ry_i(lut_y_i), .rd_o(lut_data_o)
  );

  always_comb begin
    set_v = '0;
    for (int n = 0; n < N_ENG; n++) begin
      set_v[FIELD_W*n + IB_LAST] = done[n];
      set_v[FIELD_W*n + IB_ERR]  = fault[n];
      set_v[FIELD_W*n + IB_FILL] = fill[n];
    end
    clr_v = (reg_we_i && reg_waddr_i == 4'd0) ? reg_wdata_i[IW-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (reg_we_i && reg_waddr_i == 4'd1) en_q <= reg_wdata_i[IW-1:0];
    end
  end

  assign irq_o = |(stat_q & en_q);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_raddr_i == 4'd0) reg_rdata_o = 32'(stat_q);
    if (reg_raddr_i == 4'd1) reg_rdata_o = 32'(en_q);
    for (int n = 0; n < N_ENG; n++) begin
      if (reg_raddr_i == 4'(4 + n)) reg_rdata_o = 32'(w_ptr[n]);
      if (reg_raddr_i == 4'(8 + n)) reg_rdata_o = {30'd0, err[n], ready[n]};
    end
  end

  assert_irq_off_when_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_q) == '0 && set_v == '0 && $past(set_v) == '0) |-> !irq_o);
endmodule

// File: tb/pt_refill_unit_test.sv
module pt_refill_unit_test;
  localparam int TW = 8, TH = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mem_req, mem_rvalid = 1'b0, irq;
  logic [31:0] mem_addr, mem_rdata = '0, lut_data;
  logic [2:0]  lut_x = '0;
  logic [1:0]  lut_y = '0;

  always #4 clk = ~clk;

  pt_refill_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .lut_x_i(lut_x), .lut_y_i(lut_y),
    .lut_data_o(lut_data), .irq_o(irq)
  );

  logic [31:0] mem [0:1023];
  logic [31:0] exp_t [0:TW*TH-1];
  logic [31:0] p_addr = '0;
  int          p_cnt = 0, lat = 1;
  int          total = 0, bad = 0;
  bit          finished = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      p_addr <= mem_addr;
      p_cnt  <= lat;
    end else if (p_cnt != 0) begin
      if (p_cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[p_addr[11:2]];
      end
      p_cnt <= p_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    raddr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_ready(input int e);
    logic [31:0] s;
    int t = 0;
    do begin
      @(negedge clk);
      rd(4'(8 + e), s);
      t++;
    end while (!s[0] && t < 5000);
  endtask

  task automatic tbl_check(input string req);
    int errs = 0;
    logic [31:0] a = '0, e = '0;
    for (int y = 0; y < TH; y++) begin
      for (int x = 0; x < TW; x++) begin
        lut_x = 3'(x); lut_y = 2'(y);
        #1;
        if (lut_data !== exp_t[y*TW+x]) begin
          if (errs == 0) begin a = lut_data; e = exp_t[y*TW+x]; end
          errs++;
        end
      end
    end
    chk(errs == 0, req, a, e);
  endtask

  task automatic put_desc(input int base, input int x0, input int y0, input int x1, input int y1,
                          input bit st, input int dp, input int nx);
    mem[(base >> 2)]     = {8'(y1), 8'(x1), 8'(y0), 8'(x0)};
    mem[(base >> 2) + 1] = {31'd0, st};
    mem[(base >> 2) + 2] = 32'(dp);
    mem[(base >> 2) + 3] = 32'(nx);
  endtask

  task automatic put_data(input int dp, input int n, input logic [31:0] seed);
    for (int k = 0; k < n; k++) mem[(dp >> 2) + k] = seed + 32'(k) * 32'h0001_0003;
  endtask

  task automatic apply_exp(input int x0, input int y0, input int x1, input int y1, input int dp);
    int k = 0;
    for (int y = y0; y <= y1; y++)
      for (int x = x0; x <= x1; x++) begin
        exp_t[y*TW+x] = mem[(dp >> 2) + k];
        k++;
      end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R5 act=%h exp=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s;
    logic [31:0] snap [0:TW*TH-1];
    int it;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < TW*TH; i++) exp_t[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd8, v);  chk(v == 32'd1, "R1 eng0 status", v, 32'd1);
    rd(4'd9, v);  chk(v == 32'd1, "R1 eng1 status", v, 32'd1);
    rd(4'd0, v);  chk(v == 32'd0, "R1 irq status", v, 32'd0);
    chk(irq == 1'b0, "R1 irq line", 32'(irq), 32'd0);
    tbl_check("R1 table zero");

    // R3 sweep of every rectangle, both engines, two latencies
    it = 0;
    for (int x0 = 0; x0 < TW; x0++)
      for (int x1 = x0; x1 < TW; x1++)
        for (int y0 = 0; y0 < TH; y0++)
          for (int y1 = y0; y1 < TH; y1++) begin
            int e = it % 2;
            int n = (x1 - x0 + 1) * (y1 - y0 + 1);
            lat = 1 + (it % 2);
            put_desc(32'h100, x0, y0, x1, y1, 1'b1, 32'h200, 0);
            put_data(32'h200, n, {16'(it), 16'hC0DE});
            wr(4'(4 + e), 32'h100);
            wait_ready(e);
            apply_exp(x0, y0, x1, y1, 32'h200);
            tbl_check("R3 rectangle fill");
            rd(4'd0, v);
            chk(v == (32'h82 << (8 * e)), "R8 done and filled bits", v, 32'h82 << (8 * e));
            wr(4'd0, 32'hFFFF_FFFF);
            it++;
          end

    // R2 R4 chain with a skipped descriptor
    lat = 1;
    put_desc(32'h300, 0, 0, 1, 0, 1'b1, 32'h380, 32'h310);
    put_desc(32'h310, 2, 0, 3, 0, 1'b0, 32'h3A0, 32'h320);
    put_desc(32'h320, 4, 1, 4, 2, 1'b1, 32'h3C0, 0);
    put_data(32'h380, 2, 32'h1111_0000);
    put_data(32'h3A0, 2, 32'h2222_0000);
    put_data(32'h3C0, 2, 32'h3333_0000);
    wr(4'd4, 32'h300);
    wait_ready(0);
    apply_exp(0, 0, 1, 0, 32'h380);
    apply_exp(4, 1, 4, 2, 32'h3C0);
    tbl_check("R2 R4 chain with skip");
    rd(4'd4, v); chk(v == 32'h320, "R5 pointer readback", v, 32'h320);
    rd(4'd0, v); chk(v == 32'h82, "R8 chain flags", v, 32'h82);
    wr(4'd0, 32'hFFFF_FFFF);

    // R11 nonzero write while busy is ignored
    lat = 3;
    put_desc(32'h100, 0, 0, TW - 1, TH - 1, 1'b1, 32'h200, 0);
    put_data(32'h200, TW * TH, 32'h5A5A_0000);
    put_desc(32'h400, 5, 3, 5, 3, 1'b1, 32'h480, 0);
    put_data(32'h480, 1, 32'hDEAD_0001);
    wr(4'd4, 32'h100);
    wr(4'd4, 32'h400);
    wait_ready(0);
    apply_exp(0, 0, TW - 1, TH - 1, 32'h200);
    tbl_check("R11 busy write ignored table");
    rd(4'd4, v); chk(v == 32'h100, "R11 busy write ignored pointer", v, 32'h100);
    wr(4'd0, 32'hFFFF_FFFF);

    // R6 cancel mid-chain with a read in flight
    put_data(32'h200, TW * TH, 32'h7E7E_0000);
    wr(4'd4, 32'h100);
    repeat (30) @(negedge clk);
    wr(4'd4, 32'd0);
    wait_ready(0);
    for (int i = 0; i < TW*TH; i++) begin
      lut_x = 3'(i % TW); lut_y = 2'(i / TW); #1; snap[i] = lut_data;
    end
    repeat (60) @(negedge clk);
    for (int i = 0; i < TW*TH; i++) exp_t[i] = snap[i];
    tbl_check("R6 no writes after cancel");
    rd(4'd0, v); chk(v[1] == 1'b0, "R6 no chain-done after cancel", v, 32'd0);
    rd(4'd8, v); chk(v == 32'd1, "R6 ready and no error", v, 32'd1);
    wr(4'd0, 32'hFFFF_FFFF);

    // R7 faults
    lat = 1;
    wr(4'd4, 32'h104);
    wait_ready(0);
    rd(4'd8, v); chk(v == 32'd3, "R7 misaligned error status", v, 32'd3);
    rd(4'd0, v); chk(v == 32'h04, "R7 misaligned irq bit", v, 32'h04);
    wr(4'd0, 32'hFFFF_FFFF);
    put_desc(32'h140, 3, 0, 2, 0, 1'b1, 32'h200, 0);
    wr(4'd4, 32'h140);
    wait_ready(0);
    rd(4'd8, v); chk(v == 32'd3, "R7 inverted x error", v, 32'd3);
    put_desc(32'h140, 0, 2, 0, 1, 1'b1, 32'h200, 0);
    wr(4'd4, 32'h140);
    wait_ready(0);
    rd(4'd8, v); chk(v == 32'd3, "R7 inverted y error", v, 32'd3);
    put_desc(32'h140, 0, 0, 0, TH, 1'b1, 32'h200, 0);
    wr(4'd4, 32'h140);
    wait_ready(0);
    rd(4'd8, v); chk(v == 32'd3, "R7 out of range error", v, 32'd3);
    tbl_check("R7 no writes on fault");
    rd(4'd0, v); chk(v == 32'h04, "R7 error irq only", v, 32'h04);
    put_desc(32'h140, 6, 3, 7, 3, 1'b1, 32'h1C0, 0);
    put_data(32'h1C0, 2, 32'h0BAD_F00D);
    wr(4'd4, 32'h140);
    wait_ready(0);
    apply_exp(6, 3, 7, 3, 32'h1C0);
    rd(4'd8, v); chk(v == 32'd1, "R7 error cleared by start", v, 32'd1);
    wr(4'd0, 32'hFFFF_FFFF);

    // R10 both engines at once
    lat = 2;
    put_desc(32'h100, 0, 0, 3, 1, 1'b1, 32'h200, 0);
    put_data(32'h200, 8, 32'hAAAA_0000);
    put_desc(32'h500, 4, 2, 7, 3, 1'b1, 32'h600, 0);
    put_data(32'h600, 8, 32'hBBBB_0000);
    wr(4'd4, 32'h100);
    wr(4'd5, 32'h500);
    wait_ready(0);
    wait_ready(1);
    apply_exp(0, 0, 3, 1, 32'h200);
    apply_exp(4, 2, 7, 3, 32'h600);
    tbl_check("R10 concurrent engines table");
    rd(4'd0, v); chk(v == 32'h8282, "R10 both done", v, 32'h8282);
    wr(4'd0, 32'hFFFF_FFFF);

    // R9 enable gating
    lat = 1;
    put_desc(32'h100, 0, 0, 0, 0, 1'b1, 32'h200, 0);
    put_data(32'h200, 1, 32'h9999_0001);
    wr(4'd1, 32'h80);
    @(negedge clk); chk(irq == 1'b0, "R9 irq low before event", 32'(irq), 32'd0);
    wr(4'd4, 32'h100);
    wait_ready(0);
    apply_exp(0, 0, 0, 0, 32'h200);
    chk(irq == 1'b1, "R9 irq on enabled fill bit", 32'(irq), 32'd1);
    wr(4'd0, 32'h80);
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq low with only disabled bit", 32'(irq), 32'd0);
    rd(4'd0, v); chk(v == 32'h02, "R8 write-one clears only bit 7", v, 32'h02);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd1, 32'h0200);
    wr(4'd5, 32'h100);
    wait_ready(1);
    chk(irq == 1'b1, "R9 irq on engine1 done", 32'(irq), 32'd1);
    wr(4'd1, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);

    // R8 clear and set in the same cycle: set wins
    put_desc(32'h100, 0, 0, 2, 0, 1'b1, 32'h200, 0);
    put_data(32'h200, 3, 32'h4444_0000);
    wr(4'd4, 32'h100);
    forever begin
      rd(4'd8, s);
      if (s[0]) break;
      we = 1'b1; waddr = 4'd0; wdata = 32'h02;
      @(negedge clk);
    end
    we = 1'b0;
    apply_exp(0, 0, 2, 0, 32'h200);
    rd(4'd0, v); chk(v[1] == 1'b1, "R8 set wins over clear", v, 32'h82);
    wr(4'd0, 32'h02);
    rd(4'd0, v); chk(v == 32'h80, "R8 clear afterwards", v, 32'h80);
    tbl_check("R3 final table");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule